// File: doc/BRIEF.md
# Read-to-pet watchdog reset timer

This block is a watchdog that sits behind one 16-bit control/status register. Software keeps the watchdog quiet by reading that register. Every read restarts the timeout count, and it also returns the enable bit and the timer state. If the timeout runs out, the timer enters its asserted state. When the timer is asserted and enabled, the block drives a system reset output.

The count advances only on cycles where the prescaled `tick` input is high. A two-bit strap input, `tmo_sel`, is held static and picks one of four timeout lengths: 2^(BASE_EXP + STEP_EXP*sel) ticks. With the default parameters these are 2^10, 2^12, 2^14 and 2^16 ticks.

Out of reset the timer is disabled and already asserted. Software must therefore read the register once before a write of the enable bit is accepted. A write of enable=1 is ignored while the state bit is 1. A write of enable=0 always disables the timer.

Top module: `wdog_pet_reset`

## Requirements
- R1: During and after reset, `rd_data` reads 16'hFFFE, which is disabled (bit 0 = 0) and asserted (bit 2 = 1), and `sys_reset_o` is 0.
- R2: A cycle with `reg_rd` high clears the state bit (bit 2) from the next cycle on, and restarts the timeout count from zero.
- R3: With no further read, the state bit goes to 1 in the cycle after the Nth tick following the last read, where N = 2^(BASE_EXP + STEP_EXP*tmo_sel).
- R4: If every read comes fewer than N ticks after the previous one, the state bit stays 0.
- R5: A write with `wr_data[0]` = 1 sets the enable bit (bit 0) from the next cycle on, but only if the state bit is 0 in the cycle of the write. Otherwise the write is ignored.
- R6: A write with `wr_data[0]` = 0 clears the enable bit from the next cycle on, in either timer state.
- R7: `sys_reset_o` is 1 exactly when the enable bit and the state bit are both 1. An asserted but disabled timer gives 0.
- R8: The write data bits 15..1 have no effect. Read bits 15..3 and bit 1 are always 1.
- R9: Once `sys_reset_o` is 1, it stays 1 until a read occurs or a write clears the enable bit, however many ticks pass.
- R10: Cycles with `tick` low never advance the timeout count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Prescaled time-base pulse; one count step per high cycle |
| tmo_sel | input | 2 | Static strap that selects the timeout length |
| reg_rd | input | 1 | Register read strobe; each strobe cycle pets the timer |
| reg_wr | input | 1 | Register write strobe |
| wr_data | input | 16 | Write data; only bit 0 (enable) is used |
| rd_data | output | 16 | Register read value: bit 0 enable, bit 2 state, other bits 1 |
| sys_reset_o | output | 1 | System reset request |

## Verification
The bench measures the expiry tick count for each of the four strap settings. A timer that is off by one tick, or that decodes the strap wrongly, gives the wrong count. It also tries to enable the timer while it is asserted, both straight after reset and after an expiry; a design that lacks this guard would fire a reset the moment it is enabled. It checks that the reset output holds through long runs of ticks, that disabling an expired timer drops the reset while the state bit stays 1, and that idle cycles without ticks never advance the count. Throughout all of this, and under a random mix of ticks, reads and writes, a behavioural model is compared with both outputs on every clock.

// File: rtl/wdog_pet_reset.sv
module wdog_pet_reset #(
  parameter int DATA_W   = 16,
  parameter int BASE_EXP = 10,
  parameter int STEP_EXP = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [1:0]        tmo_sel,
  input  logic              reg_rd,
  input  logic              reg_wr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              sys_reset_o
);
  localparam int CW = BASE_EXP + 3 * STEP_EXP;

  logic          en;
  logic          expired;
  logic [CW-1:0] cnt;
  logic [CW-1:0] lim_m1;

  always_comb begin
    int shift;
    shift  = BASE_EXP + STEP_EXP * int'(tmo_sel);
    lim_m1 = {CW{1'b1}} >> (CW - shift);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en      <= 1'b0;
      expired <= 1'b1;
      cnt     <= '0;
    end else begin
      if (reg_wr) begin
        if (!wr_data[0])   en <= 1'b0;
        else if (!expired) en <= 1'b1;
      end
      if (reg_rd) begin
        cnt     <= '0;
        expired <= 1'b0;
      end else if (tick && !expired) begin
        if (cnt == lim_m1) begin
          cnt     <= '0;
          expired <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  assign rd_data     = {{(DATA_W-3){1'b1}}, expired, 1'b1, en};
  assign sys_reset_o = en & expired;

  a_r2_pet_clears_state: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd |=> !rd_data[2] && cnt == '0);

  a_r3_expire_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(expired) |-> $past(tick) && !$past(reg_rd) && $past(cnt) == $past(lim_m1));

  a_r5_no_enable_when_asserted: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && expired && !(reg_wr && wr_data[0] && !expired)) |=> !rd_data[0]);

  a_r9_reset_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_reset_o && !reg_rd && !(reg_wr && !wr_data[0])) |=> sys_reset_o);

  a_r10_idle_no_count: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !reg_rd) |=> $stable(cnt) && $stable(expired));
endmodule

// File: tb/wdog_pet_reset_bench.sv
module wdog_pet_reset_bench;
  localparam int BASE = 4;
  localparam int STEP = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic [1:0]  tmo_sel = 2'd0;
  logic        reg_rd = 1'b0;
  logic        reg_wr = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        sys_reset_o;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  int m_en, m_exp, m_cnt;

  wdog_pet_reset #(.DATA_W(16), .BASE_EXP(BASE), .STEP_EXP(STEP)) u_wdog_pet_reset (
    .clk(clk), .rst_n(rst_n), .tick(tick), .tmo_sel(tmo_sel),
    .reg_rd(reg_rd), .reg_wr(reg_wr), .wr_data(wr_data),
    .rd_data(rd_data), .sys_reset_o(sys_reset_o)
  );

  always #2 clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int lim_of(input int s);
    return 1 << (BASE + STEP * s);
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      m_en <= 0; m_exp <= 1; m_cnt <= 0;
    end else begin
      if (reg_wr) begin
        if (!wr_data[0]) m_en <= 0;
        else if (m_exp == 0) m_en <= 1;
      end
      if (reg_rd) begin
        m_exp <= 0; m_cnt <= 0;
      end else if (tick && m_exp == 0) begin
        if (m_cnt + 1 >= lim_of(int'(tmo_sel))) begin m_exp <= 1; m_cnt <= 0; end
        else m_cnt <= m_cnt + 1;
      end
    end
  end

  always @(negedge clk) if (cyc > 0) begin
    int exp_rd;
    exp_rd = 16'hFFFA | (m_exp << 2) | m_en;
    check(rd_data == exp_rd[15:0], "R8 model rd_data", rd_data, exp_rd);
    check(sys_reset_o == (m_en & m_exp), "R7 model sys_reset_o", sys_reset_o, m_en & m_exp);
  end

  task automatic step(input int n = 1);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pet();
    reg_rd = 1'b1; step(); reg_rd = 1'b0;
  endtask

  task automatic wr(input logic [15:0] d);
    wr_data = d; reg_wr = 1'b1; step(); reg_wr = 1'b0;
  endtask

  task automatic measure(output int n);
    pet();
    tick = 1'b1;
    n = 0;
    while (!rd_data[2] && n < 5000) begin
      step(); n++;
    end
    tick = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    int n;
    step(3);
    check(rd_data == 16'hFFFE, "R1 reset rd_data", rd_data, 16'hFFFE);
    rst_n = 1'b1;
    step();
    check(rd_data == 16'hFFFE, "R1 after reset rd_data", rd_data, 16'hFFFE);
    check(sys_reset_o == 1'b0, "R1 sys_reset_o", sys_reset_o, 0);

    wr(16'h0001);
    check(rd_data[0] == 1'b0, "R5 enable ignored while asserted", rd_data[0], 0);
    pet();
    check(rd_data[2] == 1'b0, "R2 state cleared by read", rd_data[2], 0);
    wr(16'h0001);
    check(rd_data[0] == 1'b1, "R5 enable accepted", rd_data[0], 1);
    wr(16'hFFFF);
    check(rd_data == 16'hFFFB, "R8 upper write bits no effect", rd_data, 16'hFFFB);

    tick = 1'b1;
    for (int k = 0; k < 8; k++) begin
      step(12); pet();
    end
    check(rd_data[2] == 1'b0, "R4 regular pets keep unasserted", rd_data[2], 0);
    tick = 1'b0;

    pet();
    step(200);
    check(rd_data[2] == 1'b0, "R10 no ticks no expiry", rd_data[2], 0);
    tick = 1'b1; step(lim_of(0) - 1); tick = 1'b0;
    check(rd_data[2] == 1'b0, "R10 one tick short of limit", rd_data[2], 0);
    tick = 1'b1; step(); tick = 1'b0;
    check(rd_data[2] == 1'b1, "R3 expiry on last tick", rd_data[2], 1);
    check(sys_reset_o == 1'b1, "R7 reset when enabled and asserted", sys_reset_o, 1);

    measure(n);
    check(n == lim_of(0), "R3 sel0 tick count", n, lim_of(0));
    tick = 1'b1; step(100); tick = 1'b0;
    check(sys_reset_o == 1'b1, "R9 reset holds", sys_reset_o, 1);
    pet();
    check(sys_reset_o == 1'b0, "R9 read releases reset", sys_reset_o, 0);

    tick = 1'b1; step(lim_of(0)); tick = 1'b0;
    wr(16'h0000);
    check(sys_reset_o == 1'b0, "R6 disable drops reset", sys_reset_o, 0);
    check(rd_data == 16'hFFFE, "R7 asserted disabled state", rd_data, 16'hFFFE);
    wr(16'hFFFF);
    check(rd_data[0] == 1'b0, "R5 enable ignored after expiry", rd_data[0], 0);
    pet(); wr(16'h0001); wr(16'hFFFE);
    check(rd_data[0] == 1'b0, "R6 disable while unasserted", rd_data[0], 0);

    for (int s = 1; s < 4; s++) begin
      pet();
      tmo_sel = 2'(s);
      measure(n);
      check(n == lim_of(s), "R3 strap tick count", n, lim_of(s));
    end

    tmo_sel = 2'd0;
    pet();
    for (int k = 0; k < 3000; k++) begin
      tick    = ($urandom % 3) != 0;
      reg_rd  = ($urandom % 40) == 0;
      reg_wr  = ($urandom % 30) == 0;
      wr_data = 16'($urandom);
      step();
    end
    reg_rd = 1'b0; reg_wr = 1'b0; tick = 1'b0;
    step(2);
    finish_run();
  end

  initial begin
    #400000;
    check(1'b0, "R1 watchdog expired", 0, 1);
    finish_run();
  end
endmodule